// File: doc/BRIEF.md
# Triggered Circular Sample Capture Engine

This engine records a stream of 64-bit sample words into a circular on-chip buffer, in the manner of a logic analyser. Software writes a control word that arms it. From then on every kept sample is written to the next buffer slot, and the write address wraps from the last slot back to zero. The stream can be thinned by a power-of-two decimation code. In parallel, the engine watches one of three trigger sources: an edge on one selected bit of a 32-bit debug bus, a masked match of the whole debug word, or a software pulse written through the control register.

The first trigger event starts a post-trigger delay expressed as a 7-bit count of time units, where a unit is 2^n microseconds. A microsecond prescaler on the core clock provides the time base. When the delay runs out, writing stops and the busy bit drops. The status word then shows where writing ended and whether the buffer wrapped. Software reads the captured words back through a one-cycle read port, starting from slot 0 when there was no wrap, or from the slot after the finish address when there was one.

Top module: `capture_engine`

## Requirements
- R1: A write to register 0 with bit 0 set while the engine is idle makes status bit 0 (busy) read 1 from the next cycle. The same write while busy neither restarts the capture nor clears the finish address or the wrap flag.
- R2: Buffer slots are 64-bit words counted from 0 upward. Status bits [30:16] hold the slot of the last word stored since arming, zero-extended. These bits are 0 right after arming and hold their value while idle.
- R3: Status bit 31 (wrap) is set once slot DEPTH-1 has been written during the current capture, and it stays set until the next arm. Writing then continues at slot 0, so the oldest valid word is at finish address + 1.
- R4: The rate code in control bits [12:10] selects which valid samples are stored. Code 7 stores every valid sample. A code k from 0 to 6 stores the first of each group of 2^(k+1) valid samples, counted from the arm. No sample is stored while idle.
- R5: Source code 0 in control bits [2:1] selects the bit trigger. Control bits [8:4] pick the debug-bus bit, and control bit 3 picks the edge: 0 for rising, 1 for falling. An edge of the other polarity is not a trigger.
- R6: Source code 1 selects the word trigger. The event is (debug bus AND register 1) equal to register 2.
- R7: Source code 2 selects the software trigger. The event is a write to register 0 whose bit 9 is 1 while the previously written bit 9 was 0. Source code 3 never triggers.
- R8: The delay count is in control bits [22:16] and the exponent n in bits [26:24]. An exponent of 7 is treated as 6. After the cycle that sees the trigger event, busy stays 1 for count*2^n*US_DIV + 1 more cycles, and then drops to 0.
- R9: Only the first trigger event after arming takes effect. Further events during the delay do not change when busy drops.
- R10: While idle, a read request returns the word stored at rd_addr on rd_data one cycle later, with rd_err at 0.
- R11: A read request made while busy returns zero with rd_err at 1 one cycle later.
- R12: After reset the engine is idle, with status, rd_data and rd_err all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample word valid |
| smp_data | input | 64 | Sample word |
| dbg_bus | input | 32 | Debug bus watched by the trigger |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 mask, 2 reference |
| cfg_wdata | input | 32 | Register write data |
| stat_o | output | 32 | Status: [31] wrap, [30:16] finish slot, [0] busy |
| rd_en | input | 1 | Buffer read request |
| rd_addr | input | log2(DEPTH) | Buffer slot to read |
| rd_data | output | 64 | Read data, one cycle after the request |
| rd_err | output | 1 | The last read was refused because a capture was running |

## Verification
The bench builds the engine with DEPTH=16 and US_DIV=3. With these values, a burst of twenty samples is enough to wrap the buffer and land the finish address at a known slot. The longest delay, with the exponent clamped from 7 to 6, lasts 192 cycles, so it can be counted out cycle by cycle. A behavioural model in the bench follows stores, wrap, trigger sources and the delay on every clock. Directed checks add fixed expected values for decimated slots, refused reads, ignored edges and the re-arm attempt.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2
  } cap_state_e;

  typedef enum logic [1:0] {
    SRC_BIT    = 2'd0,
    SRC_WORD   = 2'd1,
    SRC_MANUAL = 2'd2,
    SRC_NONE   = 2'd3
  } trig_src_e;

  // Control fields kept in the engine (bit positions decoded in the top).
  typedef struct packed {
    logic [2:0] expo;
    logic [6:0] mant;
    logic [2:0] rate;
    logic       man;
    logic [4:0] idx;
    logic       fall;
    trig_src_e  src;
  } ctrl_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_MASK = 2'd1;
  localparam logic [1:0] REG_CMP  = 2'd2;

endpackage

// File: rtl/cap_trigger.sv
module cap_trigger
  import cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  trig_src_e   src,
  input  logic [4:0]  bit_idx,
  input  logic        fall,
  input  logic [31:0] dbg,
  input  logic [31:0] mask,
  input  logic [31:0] cmp,
  input  logic        man_wr,
  input  logic        man_new,
  input  logic        man_old,
  output logic        fire
);

  logic prev_q, prev_d;
  logic cur, ev;

  always_comb begin
    cur    = dbg[bit_idx];
    prev_d = cur;
    case (src)
      SRC_BIT:    ev = fall ? (prev_q && !cur) : (!prev_q && cur);
      SRC_WORD:   ev = ((dbg & mask) == cmp);
      SRC_MANUAL: ev = man_wr && man_new && !man_old;
      default:    ev = 1'b0;
    endcase
    fire = armed && ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/cap_delay.sv
module cap_delay #(
  parameter int US_DIV = 80,
  localparam int PS_W = (US_DIV > 1) ? $clog2(US_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [6:0] mant,
  input  logic [2:0] expo,
  output logic       done
);

  logic [PS_W-1:0] ps_q, ps_d;
  logic [5:0]      uc_q, uc_d;
  logic [6:0]      dc_q, dc_d;
  logic [2:0]      n_eff;
  logic [5:0]      umask;
  logic            tick, upulse;

  always_comb begin
    n_eff  = (expo == 3'd7) ? 3'd6 : expo;
    umask  = (6'd1 << n_eff) - 6'd1;
    tick   = run && (ps_q == PS_W'(US_DIV - 1));
    upulse = tick && ((uc_q & umask) == umask);
    done   = run && (dc_q == 7'd0);
    ps_d = ps_q;
    uc_d = uc_q;
    dc_d = dc_q;
    if (load) begin
      ps_d = '0;
      uc_d = '0;
      dc_d = mant;
    end else if (run) begin
      ps_d = tick ? '0 : ps_q + PS_W'(1);
      if (tick)                       uc_d = uc_q + 6'd1;
      if (upulse && dc_q != 7'd0)     dc_d = dc_q - 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
      uc_q <= '0;
      dc_q <= '0;
    end else begin
      ps_q <= ps_d;
      uc_q <= uc_d;
      dc_q <= dc_d;
    end
  end

endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic          smp_valid,
  input  logic [63:0]   smp_data,
  input  logic [2:0]    rate,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] fin,
  output logic          wrap,
  output logic [63:0]   rd_data,
  output logic          rd_err
);

  logic [7:0]    dec_q, dec_d, dmask;
  logic [AW-1:0] wp_q, wp_d, fin_q, fin_d;
  logic          wrap_q, wrap_d, keep, wr_en;
  logic [63:0]   mem_q [DEPTH];

  always_comb begin
    dmask  = (8'd2 << rate) - 8'd1;
    keep   = (rate == 3'd7) || ((dec_q & dmask) == 8'd0);
    wr_en  = active && smp_valid && keep;
    dec_d  = dec_q;
    wp_d   = wp_q;
    fin_d  = fin_q;
    wrap_d = wrap_q;
    if (clear) begin
      dec_d  = '0;
      wp_d   = '0;
      fin_d  = '0;
      wrap_d = 1'b0;
    end else if (active && smp_valid) begin
      dec_d = dec_q + 8'd1;
      if (keep) begin
        fin_d = wp_q;
        wp_d  = wp_q + AW'(1);
        if (wp_q == AW'(DEPTH - 1)) wrap_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      wp_q   <= '0;
      fin_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      dec_q  <= dec_d;
      wp_q   <= wp_d;
      fin_q  <= fin_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else if (rd_en) begin
      rd_data <= active ? 64'd0 : mem_q[rd_addr];
      rd_err  <= active;
    end
  end

  assign fin  = fin_q;
  assign wrap = wrap_q;

endmodule

// File: rtl/capture_engine.sv
module capture_engine
  import cap_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int US_DIV = 80,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [63:0]   smp_data,
  input  logic [31:0]   dbg_bus,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   stat_o,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [63:0]   rd_data,
  output logic          rd_err
);

  logic [1:0]  rs_q;
  logic        rst_n_s;
  ctrl_t       ctrl_q, ctrl_d;
  logic [31:0] mask_q, mask_d, cmp_q, cmp_d;
  cap_state_e  st_q, st_d;
  logic        wr_ctrl, arm_req, busy, fire, dly_done;
  logic [AW-1:0] fin;
  logic        wrap;
  logic        unused_cfg;

  // Reset synchroniser: asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign unused_cfg = ^{cfg_wdata[31:27], cfg_wdata[23], cfg_wdata[15:13]};

  always_comb begin
    wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
    arm_req = wr_ctrl && cfg_wdata[0];
    busy    = (st_q != ST_IDLE);
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    cmp_d   = cmp_q;
    if (wr_ctrl) begin
      ctrl_d.expo = cfg_wdata[26:24];
      ctrl_d.mant = cfg_wdata[22:16];
      ctrl_d.rate = cfg_wdata[12:10];
      ctrl_d.man  = cfg_wdata[9];
      ctrl_d.idx  = cfg_wdata[8:4];
      ctrl_d.fall = cfg_wdata[3];
      ctrl_d.src  = trig_src_e'(cfg_wdata[2:1]);
    end
    if (cfg_we && cfg_addr == REG_MASK) mask_d = cfg_wdata;
    if (cfg_we && cfg_addr == REG_CMP)  cmp_d  = cfg_wdata;
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (arm_req)  st_d = ST_ARMED;
      ST_ARMED: if (fire)     st_d = ST_POST;
      ST_POST:  if (dly_done) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q <= '0;
      mask_q <= '0;
      cmp_q  <= '0;
      st_q   <= ST_IDLE;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      cmp_q  <= cmp_d;
      st_q   <= st_d;
    end
  end

  cap_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .armed   (st_q == ST_ARMED),
    .src     (ctrl_q.src),
    .bit_idx (ctrl_q.idx),
    .fall    (ctrl_q.fall),
    .dbg     (dbg_bus),
    .mask    (mask_q),
    .cmp     (cmp_q),
    .man_wr  (wr_ctrl),
    .man_new (cfg_wdata[9]),
    .man_old (ctrl_q.man),
    .fire    (fire)
  );

  cap_delay #(.US_DIV(US_DIV)) u_dly (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (fire),
    .run   (st_q == ST_POST),
    .mant  (ctrl_q.mant),
    .expo  (ctrl_q.expo),
    .done  (dly_done)
  );

  cap_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear     ((st_q == ST_IDLE) && arm_req),
    .active    (busy),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .rate      (ctrl_q.rate),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .fin       (fin),
    .wrap      (wrap),
    .rd_data   (rd_data),
    .rd_err    (rd_err)
  );

  assign stat_o = {wrap, 15'(fin), 15'd0, busy};

endmodule

// File: rtl/cap_checker.sv
module cap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_addr,
  input logic        arm_bit,
  input logic        smp_valid,
  input logic        rd_en,
  input logic [31:0] stat_o,
  input logic [63:0] rd_data,
  input logic        rd_err
);

  logic arm_wr;
  assign arm_wr = cfg_we && (cfg_addr == 2'd0) && arm_bit;

  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_o[0] && arm_wr) |=> stat_o[0]); // R1

  AST_IDLE_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_o[0] && !arm_wr) |=> $stable(stat_o)); // R2

  AST_FIN_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] && !smp_valid) |=> $stable(stat_o[30:16])); // R2

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] && stat_o[31]) |=> stat_o[31]); // R3

  AST_IDLE_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !stat_o[0]) |=> !rd_err); // R10

  AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_o[0]) |=> (rd_err && rd_data == 64'd0)); // R11

endmodule

bind capture_engine cap_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .arm_bit   (cfg_wdata[0]),
  .smp_valid (smp_valid),
  .rd_en     (rd_en),
  .stat_o    (stat_o),
  .rd_data   (rd_data),
  .rd_err    (rd_err)
);

// File: tb/sim_capture_engine.sv
`timescale 1ns/1ps
module sim_capture_engine;

  localparam int DEPTH = 16;
  localparam int USD   = 3;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [63:0]   smp_data = '0;
  logic [31:0]   dbg_bus = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   stat_o;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [63:0]   rd_data;
  logic          rd_err;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  capture_engine #(.DEPTH(DEPTH), .US_DIV(USD)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .dbg_bus(dbg_bus), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stat_o(stat_o), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sd(input int i);
    return {32'h5A00_0000 + i[31:0], 32'h0000_A500 + i[31:0]};
  endfunction

  function automatic logic [31:0] mkctrl(input int src, input int fall, input int idx,
                                         input int rate, input int mant, input int expo);
    return (32'(src) << 1) | (32'(fall) << 3) | (32'(idx) << 4) |
           (32'(rate) << 10) | (32'(mant) << 16) | (32'(expo) << 24);
  endfunction

  // ---------------- behavioural reference model ----------------
  int          m_st, m_wp, m_fin, m_vcnt, m_rem;
  bit          m_wrap, m_prev, m_err;
  logic [31:0] m_ctrl, m_mask, m_cmp;
  logic [63:0] m_rd;
  logic [63:0] m_mem [DEPTH];

  always @(posedge clk) begin : model
    bit busy, keep, cur, ev;
    int rate, n;
    if (!rst_n) begin
      m_st = 0; m_wp = 0; m_fin = 0; m_vcnt = 0; m_rem = 0;
      m_wrap = 0; m_prev = 0; m_err = 0; m_rd = '0;
      m_ctrl = '0; m_mask = '0; m_cmp = '0;
    end else begin
      busy = (m_st != 0);
      if (rd_en) begin
        if (busy) begin m_rd = '0; m_err = 1; end
        else begin m_rd = m_mem[rd_addr]; m_err = 0; end
      end
      rate = int'(m_ctrl[12:10]);
      if (busy && smp_valid) begin
        keep = (rate == 7) || ((m_vcnt % (2 << rate)) == 0);
        m_vcnt++;
        if (keep) begin
          m_mem[m_wp] = smp_data;
          m_fin = m_wp;
          if (m_wp == DEPTH - 1) m_wrap = 1;
          m_wp = (m_wp + 1) % DEPTH;
        end
      end
      cur = dbg_bus[m_ctrl[8:4]];
      case (m_ctrl[2:1])
        2'd0: ev = m_ctrl[3] ? (m_prev && !cur) : (!m_prev && cur);
        2'd1: ev = ((dbg_bus & m_mask) == m_cmp);
        2'd2: ev = cfg_we && cfg_addr == 2'd0 && cfg_wdata[9] && !m_ctrl[9];
        default: ev = 0;
      endcase
      if (m_st == 0) begin
        if (cfg_we && cfg_addr == 2'd0 && cfg_wdata[0]) begin
          m_st = 1; m_wp = 0; m_fin = 0; m_wrap = 0; m_vcnt = 0;
        end
      end else if (m_st == 1) begin
        if (ev) begin
          n = (m_ctrl[26:24] == 3'd7) ? 6 : int'(m_ctrl[26:24]);
          m_rem = int'(m_ctrl[22:16]) * (1 << n) * USD;
          m_st = 2;
        end
      end else begin
        if (m_rem == 0) m_st = 0;
        else m_rem--;
      end
      m_prev = cur;
      if (cfg_we) begin
        if (cfg_addr == 2'd0) m_ctrl = cfg_wdata;
        if (cfg_addr == 2'd1) m_mask = cfg_wdata;
        if (cfg_addr == 2'd2) m_cmp  = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 busy vs model", stat_o[0], (m_st != 0));
      chk("R2 finish vs model", stat_o[30:16], m_fin);
      chk("R3 wrap vs model", stat_o[31], m_wrap);
      chk("R10 rd_data vs model", rd_data, m_rd);
      chk("R11 rd_err vs model", rd_err, m_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic feed(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_data = sd(base + i);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rdw(input int a, output logic [63:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a[AW-1:0];
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; e = rd_err;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    logic e;
    logic [31:0] c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 status after reset", stat_o, 32'd0);
    chk("R12 rd_data after reset", rd_data, 64'd0);
    chk("R12 rd_err after reset", rd_err, 1'b0);
    cmp_on = 1'b1;

    // A: decimation by 4, software trigger, idle readback
    c = mkctrl(2, 0, 0, 1, 0, 0);
    feed(900, 3);                     // idle samples must not be stored (R4)
    wr(2'd0, c | 32'h1);
    chk("R1 busy after arm", stat_o[0], 1'b1);
    feed(0, 10);
    wr(2'd0, c | 32'h200);
    chk("R7 busy in trigger cycle", stat_o[0], 1'b1);
    @(negedge clk);
    chk("R7 idle after zero delay", stat_o[0], 1'b0);
    chk("R4 finish after decimation", stat_o[30:16], 15'd2);
    chk("R3 no wrap", stat_o[31], 1'b0);
    rdw(0, d, e); chk("R4 slot0", d, sd(0)); chk("R10 err", e, 1'b0);
    rdw(1, d, e); chk("R4 slot1", d, sd(4));
    rdw(2, d, e); chk("R10 slot2", d, sd(8));

    // B: full rate, wrap, busy read, re-arm attempt while busy
    c = mkctrl(2, 0, 0, 7, 0, 0);
    wr(2'd0, c | 32'h1);
    rdw(0, d, e);
    chk("R11 busy read data", d, 64'd0);
    chk("R11 busy read err", e, 1'b1);
    feed(100, 20);
    wr(2'd0, c | 32'h1);
    wr(2'd0, c | 32'h200);
    @(negedge clk);
    chk("R1 no restart finish", stat_o[30:16], 15'd3);
    chk("R3 wrap set", stat_o[31], 1'b1);
    rdw(4, d, e); chk("R3 oldest at finish+1", d, sd(104));
    rdw(3, d, e); chk("R2 newest at finish", d, sd(119));

    // C: falling edge on bit 5, delay 2 x 2us, retrigger ignored
    dbg_bus = '0;
    c = mkctrl(0, 1, 5, 7, 2, 1);
    wr(2'd0, c | 32'h1);
    @(negedge clk); dbg_bus = 32'h20;
    repeat (10) @(negedge clk);
    chk("R5 rising edge ignored", stat_o[0], 1'b1);
    @(negedge clk); dbg_bus = 32'h0;
    @(negedge clk);
    for (int k = 1; k <= 2 * 2 * USD; k++) begin
      @(negedge clk);
      if (k == 3) dbg_bus = 32'h20;
      if (k == 4) dbg_bus = 32'h0;
    end
    chk("R9 busy to last delay cycle", stat_o[0], 1'b1);
    @(negedge clk);
    chk("R8 idle after delay", stat_o[0], 1'b0);

    // D: masked word match, exponent 7 clamps to 6
    wr(2'd1, 32'h0000_FF00);
    wr(2'd2, 32'h0000_3400);
    dbg_bus = 32'h1234_5678;
    c = mkctrl(1, 0, 0, 7, 1, 7);
    wr(2'd0, c | 32'h1);
    repeat (5) @(negedge clk);
    chk("R6 mismatch no trigger", stat_o[0], 1'b1);
    dbg_bus = 32'hAB12_34CD;
    @(negedge clk);
    for (int k = 1; k <= 64 * USD; k++) @(negedge clk);
    chk("R8 clamped delay busy", stat_o[0], 1'b1);
    @(negedge clk);
    chk("R6 match triggered and ended", stat_o[0], 1'b0);

    // E: software trigger needs a 0 to 1 step of bit 9
    dbg_bus = '0;
    c = mkctrl(2, 0, 0, 7, 0, 0);
    wr(2'd0, c | 32'h201);
    wr(2'd0, c | 32'h200);
    repeat (3) @(negedge clk);
    chk("R7 no step no trigger", stat_o[0], 1'b1);
    wr(2'd0, c);
    wr(2'd0, c | 32'h200);
    @(negedge clk);
    chk("R7 step triggers", stat_o[0], 1'b0);

    // F: source code 3 never fires
    c = mkctrl(3, 0, 0, 7, 0, 0);
    wr(2'd0, c | 32'h1);
    dbg_bus = 32'hFFFF_FFFF;
    wr(2'd0, c | 32'h200);
    repeat (4) @(negedge clk);
    chk("R7 code 3 never triggers", stat_o[0], 1'b1);
    c = mkctrl(2, 0, 0, 7, 0, 0);
    wr(2'd0, c);
    wr(2'd0, c | 32'h200);
    @(negedge clk);
    chk("R7 recovered to idle", stat_o[0], 1'b0);

    repeat (3) @(negedge clk);
    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule